// File: doc/BRIEF.md
# Quiesce-Gated Soft Reset Sequencer

This block produces a software-requested, active-low reset pulse for a host-interface DMA bridge. The request arrives as a one-cycle trigger, which the control-register decode raises after the host writes to a user-logic register behind the first memory BAR. The block is built so that this reset cannot cut off the write that requested it.

After the trigger, the sequencer first counts a programmable settle interval. This gives the requesting write time to retire. Only cycles in which the link-idle input is high count toward the settle interval. Any busy cycle restarts the count. Once the settle interval is complete, the block waits until the link is idle, drives the reset low, and holds it for a fixed number of cycles. The default hold is derived from the clock frequency and is always longer than a 50 ms completion timeout. The block then releases the reset on its own and marks the end of the sequence with a one-cycle completion pulse.

While a sequence is in flight, a busy flag is high and further triggers have no effect. The timing parameters take microsecond and nanosecond values. Direct cycle-count overrides allow short runs in simulation.

Top module: `swrst_seq`

## Requirements
- R1: After the synchronous block reset (`srst_ni` low), `bridge_rst_no` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: A trigger sampled while idle sets `busy_o` from the next cycle on. `bridge_rst_no` stays 1 for the whole settle interval of SETTLE_CYC cycles.
- R3: The settle interval counts only consecutive cycles with `quiesce_i` high. If `quiesce_i` is sampled low during settle, the count restarts. With the last low sample at edge L, the reset falls at edge L+SETTLE_CYC+1.
- R4: After settle, `bridge_rst_no` falls only at the edge that follows a cycle in which `quiesce_i` was sampled high. While `quiesce_i` stays low, the block waits without limit.
- R5: `bridge_rst_no` stays low for exactly HOLD_CYC cycles and then returns to 1 without any input. When no override is given, HOLD_CYC is larger than 50 ms of clock cycles at CLK_HZ.
- R6: `done_o` is high for exactly one cycle. That cycle is the first cycle with `bridge_rst_no` high again. `busy_o` falls in the following cycle.
- R7: A trigger arriving while `busy_o` is 1 (during settle, hold or the done cycle) is ignored. It does not change the reset timing and does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| srst_ni | input | 1 | Synchronous block reset, active low |
| trig_i | input | 1 | One-cycle request from the control-register decode |
| quiesce_i | input | 1 | High while no link traffic is outstanding |
| bridge_rst_no | output | 1 | Registered active-low reset to the bridge |
| busy_o | output | 1 | High from trigger acceptance through the done cycle |
| done_o | output | 1 | One-cycle pulse when the reset has been released |

## Verification
A wrong state or counter shows up at the ports within one cycle as a misplaced edge on `bridge_rst_no` or `done_o`. Examples are a settle count that fails to restart or a wait state that ignores `quiesce_i`. The bench predicts the exact edge number of every reset fall, reset rise and done pulse from the trigger and idle-input history it drives. It then compares each observed event against that prediction as soon as the event appears. Any event that was not predicted is reported immediately. This covers a retrigger that restarts the sequence, and a reset that drops while the link is busy.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WAITQ,
        ST_HOLD,
        ST_DONE
    } swrst_state_e;

    typedef struct packed {
        swrst_state_e state;
        logic         rst_n;
    } swrst_regs_t;

endpackage

// File: rtl/swrst_timer.sv
// Run-length timer: hit_o flags the LIMIT-th consecutive cycle with run_i high.
// Any cycle with run_i low clears the count.
module swrst_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk_i,
    input  logic srst_ni,
    input  logic run_i,
    output logic hit_o
);
    generate
        if (LIMIT <= 1) begin : g_single
            // one cycle is enough: no storage needed
            assign hit_o = run_i;
        end else begin : g_count
            localparam int unsigned CW = $clog2(LIMIT);
            logic [CW-1:0] cnt_d, cnt_q;

            assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

            always_comb begin
                cnt_d = cnt_q;
                if (!run_i)     cnt_d = '0;
                else if (hit_o) cnt_d = '0;
                else            cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk_i) begin
                if (!srst_ni) cnt_q <= '0;
                else          cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/swrst_fsm.sv
module swrst_fsm
    import swrst_pkg::*;
(
    input  logic clk_i,
    input  logic srst_ni,
    input  logic trig_i,
    input  logic quiesce_i,
    input  logic settle_hit_i,
    input  logic hold_hit_i,
    output logic settle_run_o,
    output logic hold_run_o,
    output logic bridge_rst_no,
    output logic busy_o,
    output logic done_o
);
    swrst_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE:   if (trig_i)       r_d.state = ST_SETTLE;
            ST_SETTLE: if (settle_hit_i) r_d.state = ST_WAITQ;
            ST_WAITQ:  if (quiesce_i) begin
                r_d.state = ST_HOLD;
                r_d.rst_n = 1'b0;
            end
            ST_HOLD:   if (hold_hit_i) begin
                r_d.state = ST_DONE;
                r_d.rst_n = 1'b1;
            end
            ST_DONE:   r_d.state = ST_IDLE;
            default: begin
                r_d.state = ST_IDLE;
                r_d.rst_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!srst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.rst_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // settle only advances on idle-link cycles; a busy cycle clears it
    assign settle_run_o  = (r_q.state == ST_SETTLE) && quiesce_i;
    assign hold_run_o    = (r_q.state == ST_HOLD);
    assign bridge_rst_no = r_q.rst_n;
    assign busy_o        = (r_q.state != ST_IDLE);
    assign done_o        = (r_q.state == ST_DONE);
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq #(
    parameter int unsigned CLK_HZ         = 250_000_000,
    parameter int unsigned SETTLE_NS      = 2_000,
    parameter int unsigned HOLD_US        = 60_000,
    parameter int unsigned SIM_SETTLE_CYC = 0,
    parameter int unsigned SIM_HOLD_CYC   = 0
) (
    input  logic clk_i,
    input  logic srst_ni,
    input  logic trig_i,
    input  logic quiesce_i,
    output logic bridge_rst_no,
    output logic busy_o,
    output logic done_o
);
    localparam longint unsigned HZ64       = 64'(CLK_HZ);
    localparam longint unsigned SETTLE_RAW = (HZ64 * 64'(SETTLE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
    localparam longint unsigned SETTLE_DER = (SETTLE_RAW == 0) ? 64'd1 : SETTLE_RAW;
    localparam longint unsigned HOLD_REQ   = (HZ64 * 64'(HOLD_US)) / 64'd1_000_000;
    // floor: strictly more than 50 ms of cycles
    localparam longint unsigned HOLD_MIN   = (HZ64 * 64'd50) / 64'd1000 + 64'd1;
    localparam longint unsigned HOLD_DER   = (HOLD_REQ > HOLD_MIN) ? HOLD_REQ : HOLD_MIN;

    localparam int unsigned SETTLE_CYC = (SIM_SETTLE_CYC != 0) ? SIM_SETTLE_CYC : 32'(SETTLE_DER);
    localparam int unsigned HOLD_CYC   = (SIM_HOLD_CYC != 0)   ? SIM_HOLD_CYC   : 32'(HOLD_DER);

    logic settle_run, settle_hit;
    logic hold_run, hold_hit;

    swrst_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk_i   (clk_i),
        .srst_ni (srst_ni),
        .run_i   (settle_run),
        .hit_o   (settle_hit)
    );

    swrst_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk_i   (clk_i),
        .srst_ni (srst_ni),
        .run_i   (hold_run),
        .hit_o   (hold_hit)
    );

    swrst_fsm u_fsm (
        .clk_i         (clk_i),
        .srst_ni       (srst_ni),
        .trig_i        (trig_i),
        .quiesce_i     (quiesce_i),
        .settle_hit_i  (settle_hit),
        .hold_hit_i    (hold_hit),
        .settle_run_o  (settle_run),
        .hold_run_o    (hold_run),
        .bridge_rst_no (bridge_rst_no),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );
endmodule

// File: rtl/swrst_chk.sv
module swrst_chk #(
    parameter int unsigned HOLD_CYC = 4
) (
    input logic clk_i,
    input logic srst_ni,
    input logic trig_i,
    input logic quiesce_i,
    input logic bridge_rst_no,
    input logic busy_o,
    input logic done_o
);
    // run length of the low phase, for the R5 window
    int unsigned low_cnt;
    always_ff @(posedge clk_i) begin
        if (!srst_ni)           low_cnt <= 0;
        else if (!bridge_rst_no) low_cnt <= low_cnt + 1;
        else                    low_cnt <= 0;
    end

    assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!srst_ni)
        !busy_o |-> bridge_rst_no);

    assert_busy_from_trig_R2: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $rose(busy_o) |-> $past(trig_i));

    assert_fall_when_quiet_R4: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $fell(bridge_rst_no) |-> $past(quiesce_i));

    assert_hold_len_R5: assert property (@(posedge clk_i) disable iff (!srst_ni)
        $rose(bridge_rst_no) |-> (low_cnt == HOLD_CYC));

    assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!srst_ni)
        done_o |=> !done_o && !busy_o);

    assert_done_released_R6: assert property (@(posedge clk_i) disable iff (!srst_ni)
        done_o |-> bridge_rst_no && busy_o);
endmodule

bind swrst_seq swrst_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk_i         (clk_i),
    .srst_ni       (srst_ni),
    .trig_i        (trig_i),
    .quiesce_i     (quiesce_i),
    .bridge_rst_no (bridge_rst_no),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/swrst_seq_bench.sv
`timescale 1ns/1ps
module swrst_seq_bench;
    localparam int S = 5;
    localparam int H = 20;
    localparam int EV_FALL = 0;
    localparam int EV_RISE = 1;
    localparam int EV_DONE = 2;

    typedef struct { int kind; int cyc; } ev_t;

    logic clk = 1'b0;
    logic srst_n = 1'b0;
    logic trig = 1'b0;
    logic quiesce = 1'b1;
    logic rst_n, busy, done;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    ev_t exp_q[$];

    swrst_seq #(.SIM_SETTLE_CYC(S), .SIM_HOLD_CYC(H)) u_swrst_seq (
        .clk_i(clk), .srst_ni(srst_n), .trig_i(trig), .quiesce_i(quiesce),
        .bridge_rst_no(rst_n), .busy_o(busy), .done_o(done)
    );

    always #2 clk = ~clk;   // 250 MHz
    initial forever begin @(posedge clk); cyc++; end

    function automatic string tag(int k);
        return (k == EV_FALL) ? "R4" : (k == EV_RISE) ? "R5" : "R6";
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    task automatic push(int k, int c);
        ev_t e; e.kind = k; e.cyc = c; exp_q.push_back(e);
    endtask

    task automatic seen(int k);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, tag(k), cyc, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k && e.cyc == cyc, tag(k), cyc, e.cyc);
        end
    endtask

    // monitor: every reset edge and done pulse is compared against the queue
    initial begin
        logic prev = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (srst_n) begin
                if (prev && !rst_n) seen(EV_FALL);
                if (!prev && rst_n) seen(EV_RISE);
                if (done)           seen(EV_DONE);
            end
            prev = rst_n;
        end
    end

    task automatic at(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic start(output int n);
        @(negedge clk); trig = 1'b1; n = cyc + 1;
        @(negedge clk); trig = 1'b0;
        check(busy === 1'b1, "R2", busy, 1);
        check(rst_n === 1'b1, "R2", rst_n, 1);
    endtask

    task automatic pulse_at(int t);
        at(t); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic expect_seq(int fall);
        push(EV_FALL, fall);
        push(EV_RISE, fall + H);
        push(EV_DONE, fall + H);
    endtask

    initial begin
        int n;
        int l;
        repeat (4) @(negedge clk);
        srst_n = 1'b1;
        @(negedge clk);
        check(rst_n === 1'b1, "R1", rst_n, 1);
        check(busy === 1'b0, "R1", busy, 0);
        check(done === 1'b0, "R1", done, 0);

        // plain sequence, link idle throughout
        start(n);
        expect_seq(n + S + 1);
        at(n + S);
        check(rst_n === 1'b1, "R2", rst_n, 1);
        at(n + S + H + 2);
        check(busy === 1'b0, "R6", busy, 0);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);

        // traffic during settle restarts the count
        repeat (3) @(negedge clk);
        start(n);
        at(n + 1); quiesce = 1'b0;
        at(n + 4); quiesce = 1'b1;
        l = n + 4;
        expect_seq(l + S + 1);
        at(l + S);
        check(rst_n === 1'b1, "R3", rst_n, 1);
        at(l + S + H + 3);
        check(busy === 1'b0, "R3", busy, 0);

        // traffic after settle: wait for idle link
        repeat (3) @(negedge clk);
        start(n);
        at(n + S); quiesce = 1'b0;
        at(n + S + 10);
        check(rst_n === 1'b1, "R4", rst_n, 1);
        check(busy === 1'b1, "R4", busy, 1);
        quiesce = 1'b1;
        expect_seq(n + S + 11);
        at(n + S + 11 + H + 2);
        check(busy === 1'b0, "R4", busy, 0);

        // retriggers while busy are ignored
        repeat (3) @(negedge clk);
        start(n);
        expect_seq(n + S + 1);
        pulse_at(n + 2);
        pulse_at(n + S + 3);
        pulse_at(n + S + 1 + H);
        at(n + S + H + 2);
        check(busy === 1'b0, "R7", busy, 0);
        repeat (30) @(negedge clk);
        check(busy === 1'b0, "R7", busy, 0);
        check(rst_n === 1'b1, "R7", rst_n, 1);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        check(1'b0, "watchdog", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule